// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

The block manages a port of `NPINS` pins. Each pin belongs either to a software-driven GPIO function or to one of four peripheral functions (A, B, C, D). A per-pin ownership bit chooses between the two. A two-bit selector, split across two separate select registers, picks the peripheral. When the GPIO owns a pin, software sets whether the pad is driven and what level it drives. When a peripheral owns it, the chosen peripheral's enable and data go to the pad. A pull-up control bit reaches the pad whoever owns the pin.

Each pad input passes through a two-flop synchronizer. That synchronized level is visible to software and is also given to every peripheral. An optional per-pin glitch filter follows it. After the filter comes an edge detector with a per-pin trigger mode. A qualifying edge latches a per-pin flag, and software clears the flag by writing ones to it. The interrupt output is the OR over all pins of flag AND enable.

Software reaches the block through a synchronous write/read bus. The address is split into a register index (`bus_addr[5:2]`) and a write operation (`bus_addr[1:0]`).

Top module: `gpio_mux_port`

## Requirements
- R1: After reset, the ownership register (index 0) reads all ones and every other register reads 0. `pad_oe`, `pad_out`, `pad_pu` and `irq` are 0.
- R2: While a pin's ownership bit is 1, `pad_oe` follows the pin's bit in the drive-enable register (index 3) and `pad_out` follows its bit in the level register (index 4). The change appears one clock after the register changes.
- R3: While a pin's ownership bit is 0, the selector {index 2 bit, index 1 bit} picks the peripheral: 00 = A, 01 = B, 10 = C, 11 = D. `pad_oe`/`pad_out` then copy `periph_oe`/`periph_do` at bit `f*NPINS + pin`, where f = 0 for A through 3 for D.
- R4: `pad_pu` follows the pull-up register (index 5) for every pin, whoever owns it.
- R5: `bus_addr[1:0]` selects the write operation on registers 0 to 9: 0 replaces the register, 1 ORs `bus_wdata` in, 2 clears the bits set in `bus_wdata`, 3 inverts the bits set in `bus_wdata`.
- R6: Reading index 11 returns the pad input after two synchronizer flops. `periph_din` carries the same level. Writes to index 11 change nothing.
- R7: With a pin's filter bit set (index 6), a new input level reaches the edge detector only after it has been stable for two consecutive clocks, so a one-clock pulse raises no flag. With the filter bit clear, the same pulse is detected.
- R8: The mode {index 8 bit, index 7 bit} per pin selects the trigger: 00 any change, 01 rising edge, 10 falling edge, 11 any change.
- R9: A qualifying edge sets the pin's flag (read at index 10) whether or not the pin's interrupt is enabled. Writing index 10 clears exactly the flags whose `bus_wdata` bits are 1.
- R10: `irq` is 1 exactly when some pin has both its flag and its enable bit (index 9) set, and is registered one clock behind them.
- R11: `bus_rdata` shows the register addressed on the previous clock. Indices 12 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register index in [5:2], write operation in [1:0] |
| bus_wdata | input | NPINS | Write data, one bit per pin |
| bus_rdata | output | NPINS | Registered read data |
| pad_in | input | NPINS | Pad input levels |
| pad_oe | output | NPINS | Pad drive enable |
| pad_out | output | NPINS | Pad output level |
| pad_pu | output | NPINS | Pad pull-up enable |
| periph_oe | input | 4*NPINS | Peripheral drive enables, function f at [f*NPINS +: NPINS] |
| periph_do | input | 4*NPINS | Peripheral output data, same layout |
| periph_din | output | NPINS | Synchronized pad level for all peripherals |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is the glitch filter's rejection of a pulse that lasts exactly one clock. The pulse has to survive both synchronizer flops and still be rejected by the filter. The bench drives it on a falling edge and removes it on the next falling edge, on two pins at once, one filtered and one not. The unfiltered pin must flag and the filtered pin must not. The per-mode edge response is reached with four pins set to the four modes at once, so that a single rising step and a single falling step cover every encoding.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int IDX_W    = 4;
  localparam int OP_W     = 2;
  localparam int NUM_CTRL = 10;
  localparam int NUM_FUNC = 4;

  localparam logic [IDX_W-1:0] IDX_OWN   = 4'd0;
  localparam logic [IDX_W-1:0] IDX_SELLO = 4'd1;
  localparam logic [IDX_W-1:0] IDX_SELHI = 4'd2;
  localparam logic [IDX_W-1:0] IDX_OE    = 4'd3;
  localparam logic [IDX_W-1:0] IDX_LVL   = 4'd4;
  localparam logic [IDX_W-1:0] IDX_PU    = 4'd5;
  localparam logic [IDX_W-1:0] IDX_FEN   = 4'd6;
  localparam logic [IDX_W-1:0] IDX_MLO   = 4'd7;
  localparam logic [IDX_W-1:0] IDX_MHI   = 4'd8;
  localparam logic [IDX_W-1:0] IDX_IEN   = 4'd9;
  localparam logic [IDX_W-1:0] IDX_FLAG  = 4'd10;
  localparam logic [IDX_W-1:0] IDX_PINV  = 4'd11;

  typedef enum logic [OP_W-1:0] {
    OP_WRITE  = 2'd0,
    OP_SET    = 2'd1,
    OP_CLEAR  = 2'd2,
    OP_TOGGLE = 2'd3
  } wr_op_e;

  typedef enum logic [1:0] {
    TRIG_ANY  = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_RSV  = 2'd3
  } trig_e;

  function automatic logic [31:0] apply_op(wr_op_e op, logic [31:0] cur, logic [31:0] wd);
    case (op)
      OP_SET:    return cur | wd;
      OP_CLEAR:  return cur & ~wd;
      OP_TOGGLE: return cur ^ wd;
      default:   return wd;
    endcase
  endfunction
endpackage

// File: rtl/gpio_mux_regs.sv
module gpio_mux_regs
  import gpio_mux_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  wr_op_e           op,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] own,
  output logic [NPINS-1:0] sel_lo,
  output logic [NPINS-1:0] sel_hi,
  output logic [NPINS-1:0] oe,
  output logic [NPINS-1:0] lvl,
  output logic [NPINS-1:0] pu,
  output logic [NPINS-1:0] fen,
  output logic [NPINS-1:0] mode_lo,
  output logic [NPINS-1:0] mode_hi,
  output logic [NPINS-1:0] ien,
  output logic [NPINS-1:0] flag_clr
);
  logic [NPINS-1:0] regs [NUM_CTRL];
  logic [31:0]      nxt;
  logic             ctl_hit;

  assign ctl_hit = we && (idx < IDX_W'(NUM_CTRL));

  always_comb begin
    nxt = apply_op(op, 32'(regs[idx]), 32'(wdata));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_CTRL; k++) begin
        regs[k] <= (k == int'(IDX_OWN)) ? '1 : '0;
      end
    end else if (ctl_hit) begin
      regs[idx] <= nxt[NPINS-1:0];
    end
  end

  assign own      = regs[IDX_OWN];
  assign sel_lo   = regs[IDX_SELLO];
  assign sel_hi   = regs[IDX_SELHI];
  assign oe       = regs[IDX_OE];
  assign lvl      = regs[IDX_LVL];
  assign pu       = regs[IDX_PU];
  assign fen      = regs[IDX_FEN];
  assign mode_lo  = regs[IDX_MLO];
  assign mode_hi  = regs[IDX_MHI];
  assign ien      = regs[IDX_IEN];
  assign flag_clr = (we && idx == IDX_FLAG) ? wdata : '0;

  // R5: the clear operation leaves no written bit set
  a_r5_clear_alias: assert property (@(posedge clk) disable iff (rst)
    (we && idx == IDX_OE && op == OP_CLEAR) |=> ((oe & $past(wdata)) == '0));
endmodule

// File: rtl/gpio_mux_pin_in.sv
module gpio_mux_pin_in
  import gpio_mux_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pad_i,
  input  logic       fen,
  input  logic [1:0] mode,
  input  logic       clr,
  output logic       sync_o,
  output logic       flag_o
);
  logic s1, s2, s3, lvl, lvl_d, flag;
  logic rise, fall, hit;

  always_comb begin
    rise = lvl & ~lvl_d;
    fall = ~lvl & lvl_d;
    case (trig_e'(mode))
      TRIG_RISE: hit = rise;
      TRIG_FALL: hit = fall;
      default:   hit = rise | fall;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      s3    <= 1'b0;
      lvl   <= 1'b0;
      lvl_d <= 1'b0;
      flag  <= 1'b0;
    end else begin
      s1    <= pad_i;
      s2    <= s1;
      s3    <= s2;
      if (!fen || (s2 == s3)) lvl <= s2;
      lvl_d <= lvl;
      flag  <= (flag & ~clr) | hit;
    end
  end

  assign sync_o = s2;
  assign flag_o = flag;

  // R7: with the filter on, the accepted level only moves when the samples agreed
  a_r7_filter_stable: assert property (@(posedge clk) disable iff (rst)
    ($past(fen) && (lvl != $past(lvl))) |-> ($past(s2) == $past(s3)));
  // R8: in rising mode a new flag comes only from a low-to-high step
  a_r8_rise_only: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == 2'b01 && $rose(flag)) |-> ($past(lvl) && !$past(lvl_d)));
  // R9: a clear with no simultaneous edge empties the flag
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !hit) |=> !flag);
endmodule

// File: rtl/gpio_mux_pin_out.sv
module gpio_mux_pin_out
  import gpio_mux_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                own,
  input  logic [1:0]          sel,
  input  logic                oe,
  input  logic                lvl,
  input  logic                pu,
  input  logic [NUM_FUNC-1:0] p_oe,
  input  logic [NUM_FUNC-1:0] p_do,
  output logic                pad_oe,
  output logic                pad_out,
  output logic                pad_pu
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe  <= 1'b0;
      pad_out <= 1'b0;
      pad_pu  <= 1'b0;
    end else begin
      pad_pu <= pu;
      if (own) begin
        pad_oe  <= oe;
        pad_out <= lvl;
      end else begin
        pad_oe  <= p_oe[sel];
        pad_out <= p_do[sel];
      end
    end
  end

  // R2: a GPIO-owned pin with drive disabled is not driven
  a_r2_gpio_undriven: assert property (@(posedge clk) disable iff (rst)
    (own && !oe) |=> !pad_oe);
  // R4: pull-up does not depend on ownership
  a_r4_pullup: assert property (@(posedge clk) disable iff (rst)
    pu |=> pad_pu);
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_we,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [NPINS-1:0]          bus_wdata,
  output logic [NPINS-1:0]          bus_rdata,
  input  logic [NPINS-1:0]          pad_in,
  output logic [NPINS-1:0]          pad_oe,
  output logic [NPINS-1:0]          pad_out,
  output logic [NPINS-1:0]          pad_pu,
  input  logic [NUM_FUNC*NPINS-1:0] periph_oe,
  input  logic [NUM_FUNC*NPINS-1:0] periph_do,
  output logic [NPINS-1:0]          periph_din,
  output logic                      irq
);
  localparam int IDX_LSB = OP_W;

  logic [IDX_W-1:0] idx;
  wr_op_e           op;
  logic [NPINS-1:0] own, sel_lo, sel_hi, oe, lvl, pu, fen, mode_lo, mode_hi, ien;
  logic [NPINS-1:0] flag_clr, flags, sync;

  assign idx = bus_addr[IDX_LSB +: IDX_W];
  assign op  = wr_op_e'(bus_addr[OP_W-1:0]);

  gpio_mux_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .idx(idx), .op(op), .wdata(bus_wdata),
    .own(own), .sel_lo(sel_lo), .sel_hi(sel_hi), .oe(oe), .lvl(lvl), .pu(pu),
    .fen(fen), .mode_lo(mode_lo), .mode_hi(mode_hi), .ien(ien), .flag_clr(flag_clr)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [NUM_FUNC-1:0] p_oe, p_do;
    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_fn
      assign p_oe[f] = periph_oe[f*NPINS + i];
      assign p_do[f] = periph_do[f*NPINS + i];
    end

    gpio_mux_pin_out u_out (
      .clk(clk), .rst(rst), .own(own[i]), .sel({sel_hi[i], sel_lo[i]}),
      .oe(oe[i]), .lvl(lvl[i]), .pu(pu[i]), .p_oe(p_oe), .p_do(p_do),
      .pad_oe(pad_oe[i]), .pad_out(pad_out[i]), .pad_pu(pad_pu[i])
    );

    gpio_mux_pin_in u_in (
      .clk(clk), .rst(rst), .pad_i(pad_in[i]), .fen(fen[i]),
      .mode({mode_hi[i], mode_lo[i]}), .clr(flag_clr[i]),
      .sync_o(sync[i]), .flag_o(flags[i])
    );
  end

  assign periph_din = sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= |(flags & ien);
      case (idx)
        IDX_OWN:   bus_rdata <= own;
        IDX_SELLO: bus_rdata <= sel_lo;
        IDX_SELHI: bus_rdata <= sel_hi;
        IDX_OE:    bus_rdata <= oe;
        IDX_LVL:   bus_rdata <= lvl;
        IDX_PU:    bus_rdata <= pu;
        IDX_FEN:   bus_rdata <= fen;
        IDX_MLO:   bus_rdata <= mode_lo;
        IDX_MHI:   bus_rdata <= mode_hi;
        IDX_IEN:   bus_rdata <= ien;
        IDX_FLAG:  bus_rdata <= flags;
        IDX_PINV:  bus_rdata <= sync;
        default:   bus_rdata <= '0;
      endcase
    end
  end

  // R10: no enabled pin, no request
  a_r10_irq_gated: assert property (@(posedge clk) disable iff (rst)
    (ien == '0) |=> !irq);
  // R10: a request always has an enabled flagged pin behind it
  a_r10_irq_source: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(ien) != '0));
endmodule

// File: tb/gpio_mux_port_bench.sv
module gpio_mux_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           bus_we = 1'b0;
  logic [5:0]     bus_addr = '0;
  logic [N-1:0]   bus_wdata = '0;
  logic [N-1:0]   bus_rdata;
  logic [N-1:0]   pad_in = '0;
  logic [N-1:0]   pad_oe, pad_out, pad_pu, periph_din;
  logic [4*N-1:0] periph_oe, periph_do;
  logic           irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mux_port #(.NPINS(N), .ADDR_W(6)) u_gpio_mux_port (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pu(pad_pu), .periph_oe(periph_oe), .periph_do(periph_do),
    .periph_din(periph_din), .irq(irq)
  );

  // {index, op, wdata, expected readback}
  localparam logic [21:0] VEC [8] = '{
    {4'd4, 2'd0, 8'hA5, 8'hA5},
    {4'd4, 2'd1, 8'h0F, 8'hAF},
    {4'd4, 2'd2, 8'hA0, 8'h0F},
    {4'd4, 2'd3, 8'hFF, 8'hF0},
    {4'd4, 2'd0, 8'h3C, 8'h3C},
    {4'd0, 2'd2, 8'h01, 8'hFE},
    {4'd0, 2'd3, 8'h03, 8'hFD},
    {4'd0, 2'd1, 8'h02, 8'hFF}
  };

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] idx, logic [1:0] op, logic [N-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = {idx, op}; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] idx, output logic [N-1:0] d);
    @(negedge clk);
    bus_addr = {idx, 2'b00};
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [N-1:0] exp_mux(logic [N-1:0] own, logic [N-1:0] lo,
      logic [N-1:0] hi, logic [N-1:0] g, logic [4*N-1:0] p);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      int f;
      f = 2*int'(hi[i]) + int'(lo[i]);
      r[i] = own[i] ? g[i] : p[f*N + i];
    end
    return r;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] r;
    periph_oe = {8'hF0, 8'hCC, 8'hAA, 8'h0F};
    periph_do = {8'h12, 8'h34, 8'h56, 8'h78};
    settle(3);
    rst = 1'b0;
    settle(1);

    // R1 reset state
    chk("R1 pad_oe", pad_oe, '0);
    chk("R1 pad_out", pad_out, '0);
    chk("R1 pad_pu", pad_pu, '0);
    chk("R1 irq", {7'd0, irq}, '0);
    rd(4'd0, r); chk("R1 own reset", r, 8'hFF);
    rd(4'd3, r); chk("R1 oe reset", r, 8'h00);
    rd(4'd7, r); chk("R1 mode reset", r, 8'h00);

    // R5 write operation table
    foreach (VEC[k]) begin
      wr(VEC[k][21:18], VEC[k][17:16], VEC[k][15:8]);
      rd(VEC[k][21:18], r);
      chk("R5 write alias", r, VEC[k][7:0]);
    end

    // R2 GPIO ownership
    wr(4'd3, 2'd0, 8'h3C);
    wr(4'd4, 2'd0, 8'h66);
    settle(2);
    chk("R2 gpio pad_oe", pad_oe, 8'h3C);
    chk("R2 gpio pad_out", pad_out, 8'h66);

    // R3 peripheral selection, each function then a mix
    wr(4'd0, 2'd0, 8'h00);
    for (int m = 0; m < 5; m++) begin
      logic [N-1:0] lo, hi;
      lo = (m == 4) ? 8'h55 : ((m % 2 == 1) ? 8'hFF : 8'h00);
      hi = (m == 4) ? 8'h33 : ((m >= 2) ? 8'hFF : 8'h00);
      wr(4'd1, 2'd0, lo);
      wr(4'd2, 2'd0, hi);
      settle(2);
      chk("R3 periph pad_oe", pad_oe, exp_mux(8'h00, lo, hi, 8'h00, periph_oe));
      chk("R3 periph pad_out", pad_out, exp_mux(8'h00, lo, hi, 8'h00, periph_do));
    end
    // mixed ownership: low nibble GPIO
    wr(4'd0, 2'd0, 8'h0F);
    settle(2);
    chk("R2 R3 mixed pad_oe", pad_oe, exp_mux(8'h0F, 8'h55, 8'h33, 8'h3C, periph_oe));
    chk("R2 R3 mixed pad_out", pad_out, exp_mux(8'h0F, 8'h55, 8'h33, 8'h66, periph_do));

    // R4 pull-up
    wr(4'd5, 2'd0, 8'h81);
    settle(2);
    chk("R4 pad_pu", pad_pu, 8'h81);

    // R6 pin value
    pad_in = 8'h5A;
    settle(4);
    rd(4'd11, r); chk("R6 pin value", r, 8'h5A);
    chk("R6 periph_din", periph_din, 8'h5A);
    wr(4'd11, 2'd0, 8'hFF);
    rd(4'd11, r); chk("R6 pin value write ignored", r, 8'h5A);

    // R8 R9 edge modes: pin0 any, pin1 rise, pin2 fall, pin3 reserved
    pad_in = 8'h00;
    settle(6);
    wr(4'd10, 2'd0, 8'hFF);
    wr(4'd7, 2'd0, 8'h0A);
    wr(4'd8, 2'd0, 8'h0C);
    rd(4'd10, r); chk("R9 flags cleared", r, 8'h00);
    pad_in = 8'h0F;
    settle(6);
    rd(4'd10, r); chk("R8 rising modes", r, 8'h0B);
    chk("R9 R10 flag without enable", {7'd0, irq}, 8'h00);
    wr(4'd10, 2'd0, 8'hFF);
    pad_in = 8'h00;
    settle(6);
    rd(4'd10, r); chk("R8 falling modes", r, 8'h0D);
    wr(4'd10, 2'd0, 8'h01);
    rd(4'd10, r); chk("R9 partial clear", r, 8'h0C);

    // R10 interrupt gating
    wr(4'd9, 2'd0, 8'h02);
    settle(3);
    chk("R10 irq off for unflagged enable", {7'd0, irq}, 8'h00);
    wr(4'd9, 2'd0, 8'h04);
    settle(3);
    chk("R10 irq on", {7'd0, irq}, 8'h01);
    wr(4'd10, 2'd0, 8'hFF);
    settle(3);
    chk("R10 irq drops after clear", {7'd0, irq}, 8'h00);
    wr(4'd9, 2'd0, 8'h00);

    // R7 glitch filter: pin4 filtered, pin5 not, one-clock pulse on both
    wr(4'd6, 2'd0, 8'h10);
    @(negedge clk); pad_in = 8'h30;
    @(negedge clk); pad_in = 8'h00;
    settle(8);
    rd(4'd10, r); chk("R7 pulse filtered on pin4 only", r, 8'h20);
    wr(4'd10, 2'd0, 8'hFF);
    pad_in = 8'h10;
    settle(8);
    rd(4'd10, r); chk("R7 stable level accepted", r, 8'h10);

    // R11 unused index
    rd(4'd15, r); chk("R11 unused reads zero", r, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule